// File: doc/BRIEF.md
# Converter Calibration Step Sequencer

This block is the digital controller that starts and times calibration steps for an oversampling analog-to-digital converter. A calibration request arrives as a strobe input that must stay high for a minimum number of master-clock cycles. While the strobe is held past that minimum, the block asks the rest of the converter to clear its state. The step itself begins in the cycle after the strobe falls. Two mode-select inputs are captured when the strobe rises. Together they choose one of four calibrations: a self calibration, a one-step system offset calibration, or one of the two ordered steps of a system calibration (offset first, gain second).

Each calibration runs for its own fixed number of clock cycles, and each count is a parameter so that simulation can use short counts. Calibrations that measure both end points are split into a zero-scale phase and a full-scale phase. The block issues a capture strobe at the end of each phase. The not-ready flag rises when a step starts and falls when it ends. On completion the block emits a one-cycle done pulse together with the finished mode code. After a system offset step it also tells the output stage to force the all-zeros word, and after a system gain step the all-ones word. A gain step requested with no completed offset step before it is refused, and a sticky error flag records the refusal.

Top module: `calseq_ctrl`

State machine states:
- `ST_IDLE`: waiting.
- `ST_HOLD`: strobe high, counting hold cycles.
- `ST_ZERO`: zero-scale phase running.
- `ST_FULL`: full-scale phase running.

Transitions:
- `ST_IDLE` to `ST_HOLD` on a rising strobe.
- `ST_HOLD` to `ST_IDLE` on a fall after a short hold, or on a refused gain request.
- `ST_HOLD` to `ST_ZERO` on a valid fall when the mode has a zero-scale phase.
- `ST_HOLD` to `ST_FULL` on a valid fall in gain mode.
- `ST_ZERO` to `ST_FULL` when the timer expires in a two-phase mode.
- `ST_ZERO` to `ST_IDLE` when the timer expires in system-offset mode.
- `ST_FULL` to `ST_IDLE` when the timer expires.

## Requirements
- R1: A strobe held high for fewer than HOLD_MIN clock samples is ignored: no step starts, and `not_ready`, `seq_error` and `busy` keep their values.
- R2: While the strobe has been high for at least HOLD_MIN samples and the block is idle-holding, `conv_clear` is high. A valid step starts (`busy` high) in the cycle after the strobe is sampled low.
- R3: The mode code {`mode_sel_a`,`mode_sel_b`} is captured on the strobe's rising sample and shown on `latched_mode`. Changes on the select inputs after that sample do not alter the running step.
- R4: Mode codes and step lengths in busy cycles: 2'b00 self calibration lasts CYC_SELF, 2'b11 system offset lasts CYC_SYS_OFS, 2'b01 system gain lasts CYC_SYS_GAIN, 2'b10 one-step offset lasts CYC_ONE.
- R5: `not_ready` is 1 out of reset, rises when a step starts, stays high for the whole step, and falls in the cycle after the last busy cycle.
- R6: Strobe activity while `busy` is high is ignored. It neither restarts nor extends the step, and it starts no step after the current one ends.
- R7: A gain request (2'b01) with no system offset step completed since reset or since the last gain step is refused. `seq_error` is set and stays set until reset, `not_ready` is unchanged, and no step starts.
- R8: When a step ends, `step_done` is high for exactly one cycle and `done_mode` carries its mode code. `force_zero` pulses with it for mode 2'b11 and `force_full` for mode 2'b01; neither pulses for other modes.
- R9: Modes 2'b00 and 2'b10 pulse `cap_zero` after floor(N/2) busy cycles and `cap_full` at completion. Mode 2'b11 pulses only `cap_zero`, at completion. Mode 2'b01 pulses only `cap_full`, at completion.
- R10: Reset values: `busy`=0, `not_ready`=1, `seq_error`=0, `latched_mode`=2'b00, and all pulse outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_strobe | input | 1 | Calibration request strobe |
| mode_sel_a | input | 1 | Upper mode-select bit |
| mode_sel_b | input | 1 | Lower mode-select bit |
| latched_mode | output | 2 | Mode code captured at the strobe's rise |
| busy | output | 1 | A calibration step is running |
| not_ready | output | 1 | Output data not valid (data-ready flag, active high) |
| conv_clear | output | 1 | Converter state clear request during a valid hold |
| cap_zero | output | 1 | Zero-scale capture strobe |
| cap_full | output | 1 | Full-scale capture strobe |
| force_zero | output | 1 | Force all-zeros output word |
| force_full | output | 1 | Force all-ones output word |
| step_done | output | 1 | One-cycle completion pulse |
| done_mode | output | 2 | Mode code of the last completed step |
| seq_error | output | 1 | Sticky out-of-order gain request flag |

## Verification
Some properties are checked by assertions on every cycle:
- `not_ready` stays high while busy.
- Every step start is preceded by a valid hold.
- The latched mode is stable during a step.
- The force pulses are exclusive and tied to the correct done mode.
- Done is a single cycle that follows busy.
- The error flag is sticky.

Other behaviour only the bench scenarios can show:
- The exact step length for each mode and where the zero-scale capture falls.
- Short and intruding strobes being ignored, and later changes on the selects having no effect.
- The ordering rule that refuses a gain step.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    typedef enum logic [1:0] {
        MODE_SELF     = 2'b00,
        MODE_SYS_GAIN = 2'b01,
        MODE_ONE_OFS  = 2'b10,
        MODE_SYS_OFS  = 2'b11
    } cal_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_ZERO = 2'd2,
        ST_FULL = 2'd3
    } seq_state_e;

endpackage

// File: rtl/calseq_hold_watch.sv
module calseq_hold_watch #(
    parameter int unsigned HOLD_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_in,
    output logic rise,
    output logic fall,
    output logic held_long
);
    localparam int unsigned CW = $clog2(HOLD_MIN + 1);

    logic          cal_prev;
    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_prev <= 1'b0;
            hold_cnt <= '0;
        end else begin
            cal_prev <= cal_in;
            if (!cal_in) begin
                hold_cnt <= '0;
            end else if (!cal_prev) begin
                hold_cnt <= CW'(1);
            end else if (hold_cnt < CW'(HOLD_MIN)) begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    assign rise      = cal_in & ~cal_prev;
    assign fall      = ~cal_in & cal_prev;
    assign held_long = (hold_cnt >= CW'(HOLD_MIN));

endmodule

// File: rtl/calseq_phase_lut.sv
module calseq_phase_lut
    import calseq_pkg::*;
#(
    parameter int unsigned CYC_SELF     = 3145655,
    parameter int unsigned CYC_SYS_OFS  = 1052599,
    parameter int unsigned CYC_SYS_GAIN = 1068813,
    parameter int unsigned CYC_ONE      = 2117389,
    parameter int unsigned LEN_W        = 22
) (
    input  cal_mode_e        mode,
    output logic [LEN_W-1:0] zero_len,
    output logic [LEN_W-1:0] full_len
);
    localparam int unsigned SELF_Z = CYC_SELF / 2;
    localparam int unsigned SELF_F = CYC_SELF - SELF_Z;
    localparam int unsigned ONE_Z  = CYC_ONE / 2;
    localparam int unsigned ONE_F  = CYC_ONE - ONE_Z;

    always_comb begin
        zero_len = '0;
        full_len = '0;
        unique case (mode)
            MODE_SELF: begin
                zero_len = LEN_W'(SELF_Z);
                full_len = LEN_W'(SELF_F);
            end
            MODE_ONE_OFS: begin
                zero_len = LEN_W'(ONE_Z);
                full_len = LEN_W'(ONE_F);
            end
            MODE_SYS_OFS: begin
                zero_len = LEN_W'(CYC_SYS_OFS);
            end
            MODE_SYS_GAIN: begin
                full_len = LEN_W'(CYC_SYS_GAIN);
            end
            default: begin
                zero_len = '0;
                full_len = '0;
            end
        endcase
    end

endmodule

// File: rtl/calseq_timer.sv
module calseq_timer #(
    parameter int unsigned W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
    import calseq_pkg::*;
#(
    parameter int unsigned HOLD_MIN     = 4,
    parameter int unsigned CYC_SELF     = 3145655,
    parameter int unsigned CYC_SYS_OFS  = 1052599,
    parameter int unsigned CYC_SYS_GAIN = 1068813,
    parameter int unsigned CYC_ONE      = 2117389
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cal_strobe,
    input  logic       mode_sel_a,
    input  logic       mode_sel_b,
    output logic [1:0] latched_mode,
    output logic       busy,
    output logic       not_ready,
    output logic       conv_clear,
    output logic       cap_zero,
    output logic       cap_full,
    output logic       force_zero,
    output logic       force_full,
    output logic       step_done,
    output logic [1:0] done_mode,
    output logic       seq_error
);
    localparam int unsigned MAX_AB  = (CYC_SELF > CYC_ONE) ? CYC_SELF : CYC_ONE;
    localparam int unsigned MAX_CD  = (CYC_SYS_OFS > CYC_SYS_GAIN) ? CYC_SYS_OFS : CYC_SYS_GAIN;
    localparam int unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned LEN_W   = $clog2(MAX_CYC + 1);

    logic             cal_rise;
    logic             cal_fall;
    logic             held_long;
    cal_mode_e        mode_q;
    logic [LEN_W-1:0] zero_len;
    logic [LEN_W-1:0] full_len;
    logic             tmr_load;
    logic [LEN_W-1:0] tmr_val;
    logic             tmr_done;
    seq_state_e       state_q;
    seq_state_e       state_d;
    logic             ofs_done_q;
    logic             gain_blocked;
    logic             run_now;
    logic             start_step;
    logic             reject;
    logic             finish;
    logic             zero_end;

    calseq_hold_watch #(
        .HOLD_MIN (HOLD_MIN)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_in    (cal_strobe),
        .rise      (cal_rise),
        .fall      (cal_fall),
        .held_long (held_long)
    );

    calseq_phase_lut #(
        .CYC_SELF     (CYC_SELF),
        .CYC_SYS_OFS  (CYC_SYS_OFS),
        .CYC_SYS_GAIN (CYC_SYS_GAIN),
        .CYC_ONE      (CYC_ONE),
        .LEN_W        (LEN_W)
    ) u_lut (
        .mode     (mode_q),
        .zero_len (zero_len),
        .full_len (full_len)
    );

    calseq_timer #(
        .W (LEN_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign gain_blocked = (mode_q == MODE_SYS_GAIN) && !ofs_done_q;
    assign run_now      = (state_q == ST_ZERO) || (state_q == ST_FULL);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cal_rise) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (cal_fall) begin
                    if (!held_long || gain_blocked) state_d = ST_IDLE;
                    else if (zero_len != '0)        state_d = ST_ZERO;
                    else                            state_d = ST_FULL;
                end
            end
            ST_ZERO: begin
                if (tmr_done) state_d = (full_len != '0) ? ST_FULL : ST_IDLE;
            end
            ST_FULL: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_load   = ((state_d == ST_ZERO) && (state_q != ST_ZERO)) ||
                        ((state_d == ST_FULL) && (state_q != ST_FULL));
    assign tmr_val    = (state_d == ST_ZERO) ? (zero_len - 1'b1) : (full_len - 1'b1);
    assign start_step = (state_q == ST_HOLD) && ((state_d == ST_ZERO) || (state_d == ST_FULL));
    assign reject     = (state_q == ST_HOLD) && cal_fall && held_long && gain_blocked;
    assign finish     = run_now && (state_d == ST_IDLE);
    assign zero_end   = (state_q == ST_ZERO) && tmr_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_SELF;
            not_ready  <= 1'b1;
            cap_zero   <= 1'b0;
            cap_full   <= 1'b0;
            force_zero <= 1'b0;
            force_full <= 1'b0;
            step_done  <= 1'b0;
            done_mode  <= 2'b00;
            seq_error  <= 1'b0;
            ofs_done_q <= 1'b0;
        end else begin
            cap_zero   <= zero_end;
            cap_full   <= (state_q == ST_FULL) && tmr_done;
            step_done  <= finish;
            force_zero <= finish && (mode_q == MODE_SYS_OFS);
            force_full <= finish && (mode_q == MODE_SYS_GAIN);
            if ((state_q == ST_IDLE) && cal_rise) begin
                mode_q <= cal_mode_e'({mode_sel_a, mode_sel_b});
            end
            if (start_step) begin
                not_ready <= 1'b1;
            end else if (finish) begin
                not_ready <= 1'b0;
            end
            if (finish) begin
                done_mode <= mode_q;
                if (mode_q == MODE_SYS_OFS)       ofs_done_q <= 1'b1;
                else if (mode_q == MODE_SYS_GAIN) ofs_done_q <= 1'b0;
            end
            if (reject) begin
                seq_error <= 1'b1;
            end
        end
    end

    assign latched_mode = mode_q;
    assign busy         = run_now;
    assign conv_clear   = (state_q == ST_HOLD) && held_long;

endmodule

// File: rtl/calseq_ctrl_chk.sv
module calseq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] latched_mode,
    input logic       busy,
    input logic       not_ready,
    input logic       conv_clear,
    input logic       force_zero,
    input logic       force_full,
    input logic       step_done,
    input logic [1:0] done_mode,
    input logic       seq_error
);
    assert_start_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_clear));

    assert_mode_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(latched_mode));

    assert_flag_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> not_ready);

    assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_error) |-> seq_error);

    assert_done_follows_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> (!busy && $past(busy)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    assert_force_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({force_zero, force_full}));

    assert_force_zero_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |-> (step_done && done_mode == 2'b11));

    assert_force_full_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_full |-> (step_done && done_mode == 2'b01));

    assert_flag_drops_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> !not_ready);
endmodule

bind calseq_ctrl calseq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .latched_mode (latched_mode),
    .busy         (busy),
    .not_ready    (not_ready),
    .conv_clear   (conv_clear),
    .force_zero   (force_zero),
    .force_full   (force_full),
    .step_done    (step_done),
    .done_mode    (done_mode),
    .seq_error    (seq_error)
);

// File: tb/calseq_ctrl_bench.sv
`timescale 1ns/1ps
module calseq_ctrl_bench;
    localparam int HOLD = 4;
    localparam int C_SELF = 20;
    localparam int C_OFS  = 8;
    localparam int C_GAIN = 10;
    localparam int C_ONE  = 14;
    localparam int NVEC   = 7;

    // stimulus table: mode code, hold samples, expected start, expected error flag after
    localparam int V_MODE  [NVEC] = '{0, 3, 1, 2, 3, 1, 3};
    localparam int V_HOLD  [NVEC] = '{4, 6, 4, 9, 3, 5, 4};
    localparam int V_START [NVEC] = '{1, 1, 1, 1, 0, 0, 1};
    localparam int V_ERR   [NVEC] = '{0, 0, 0, 0, 0, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_strobe = 1'b0;
    logic mode_sel_a = 1'b0;
    logic mode_sel_b = 1'b0;
    logic [1:0] latched_mode;
    logic busy, not_ready, conv_clear, cap_zero, cap_full;
    logic force_zero, force_full, step_done, seq_error;
    logic [1:0] done_mode;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    calseq_ctrl #(
        .HOLD_MIN     (HOLD),
        .CYC_SELF     (C_SELF),
        .CYC_SYS_OFS  (C_OFS),
        .CYC_SYS_GAIN (C_GAIN),
        .CYC_ONE      (C_ONE)
    ) u_calseq_ctrl (
        .clk (clk), .rst_n (rst_n), .cal_strobe (cal_strobe),
        .mode_sel_a (mode_sel_a), .mode_sel_b (mode_sel_b),
        .latched_mode (latched_mode), .busy (busy), .not_ready (not_ready),
        .conv_clear (conv_clear), .cap_zero (cap_zero), .cap_full (cap_full),
        .force_zero (force_zero), .force_full (force_full), .step_done (step_done),
        .done_mode (done_mode), .seq_error (seq_error)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int step_len(input int m);
        case (m)
            0: return C_SELF;
            3: return C_OFS;
            1: return C_GAIN;
            default: return C_ONE;
        endcase
    endfunction

    // One calibration request; inputs change at falling edges only.
    task automatic run_step(input int m, input int hold, input bit exp_start,
                            input int exp_err, input bit intrude, input bit flip);
        int len, k, zidx, fidx, nz, nf, nr_before;
        len = step_len(m);
        nr_before = int'(not_ready);
        @(negedge clk);
        mode_sel_a = m[1];
        mode_sel_b = m[0];
        cal_strobe = 1'b1;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            if (flip && h == 0) begin
                mode_sel_a = ~mode_sel_a;
                mode_sel_b = ~mode_sel_b;
            end
        end
        // R2: clear request visible only when hold reached the minimum
        check(conv_clear == (hold >= HOLD), "R2 conv_clear", int'(conv_clear), int'(hold >= HOLD));
        cal_strobe = 1'b0;
        @(negedge clk);
        if (!exp_start) begin
            for (int w = 0; w < 6; w++) begin
                if (busy || step_done) begin
                    check(1'b0, (m == 1) ? "R7 no start" : "R1 no start", int'(busy), 0);
                end
                @(negedge clk);
            end
            check(int'(not_ready) == nr_before, (m == 1) ? "R7 not_ready" : "R1 not_ready",
                  int'(not_ready), nr_before);
            check(int'(seq_error) == exp_err, (m == 1) ? "R7 seq_error" : "R1 seq_error",
                  int'(seq_error), exp_err);
            return;
        end
        check(busy == 1'b1, "R2 start", int'(busy), 1);
        check(int'(latched_mode) == m, "R3 latched_mode", int'(latched_mode), m);
        k = 0; zidx = -1; fidx = -1; nz = 0; nf = 0;
        while (busy && k < 200) begin
            if (!not_ready) check(1'b0, "R5 not_ready in step", 0, 1);
            if (cap_zero) begin zidx = k; nz++; end
            if (cap_full) begin fidx = k; nf++; end
            if (intrude && k == 3) begin
                mode_sel_a = 1'b0; mode_sel_b = 1'b1; cal_strobe = 1'b1;
            end
            if (intrude && k == 9) cal_strobe = 1'b0;
            k++;
            @(negedge clk);
        end
        if (cap_zero) begin zidx = k; nz++; end
        if (cap_full) begin fidx = k; nf++; end
        check(k == len, "R4 length", k, len);
        check(step_done == 1'b1, "R8 step_done", int'(step_done), 1);
        check(int'(done_mode) == m, "R8 done_mode", int'(done_mode), m);
        check(force_zero == (m == 3), "R8 force_zero", int'(force_zero), int'(m == 3));
        check(force_full == (m == 1), "R8 force_full", int'(force_full), int'(m == 1));
        check(not_ready == 1'b0, "R5 not_ready end", int'(not_ready), 0);
        check(int'(seq_error) == exp_err, "R7 seq_error", int'(seq_error), exp_err);
        if (m == 0 || m == 2) begin
            check(nz == 1 && zidx == len / 2, "R9 cap_zero split", zidx, len / 2);
            check(nf == 1 && fidx == len, "R9 cap_full split", fidx, len);
        end else if (m == 3) begin
            check(nz == 1 && zidx == len && nf == 0, "R9 cap offset", zidx, len);
        end else begin
            check(nf == 1 && fidx == len && nz == 0, "R9 cap gain", fidx, len);
        end
        @(negedge clk);
        check(step_done == 1'b0, "R8 single pulse", int'(step_done), 0);
        if (intrude) begin
            for (int w = 0; w < 8; w++) begin
                if (busy) check(1'b0, "R6 no restart", 1, 0);
                @(negedge clk);
            end
            check(int'(done_mode) == m, "R6 done_mode", int'(done_mode), m);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 busy", int'(busy), 0);
        check(not_ready == 1'b1, "R10 not_ready", int'(not_ready), 1);
        check(seq_error == 1'b0, "R10 seq_error", int'(seq_error), 0);
        check(latched_mode == 2'b00, "R10 latched_mode", int'(latched_mode), 0);
        check({cap_zero, cap_full, force_zero, force_full, step_done} == 5'b0,
              "R10 pulses", int'({cap_zero, cap_full, force_zero, force_full, step_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_step(V_MODE[i], V_HOLD[i], V_START[i] != 0, V_ERR[i], 1'b0, 1'b0);
        end

        // R6: strobe during a running self calibration is ignored
        run_step(0, 4, 1'b1, 1, 1'b1, 1'b0);
        // R3: select inputs flipped after the rising sample (offset stays offset)
        run_step(3, 5, 1'b1, 1, 1'b0, 1'b1);

        // reset in the middle of a step, then R10 again
        @(negedge clk);
        mode_sel_a = 1'b1; mode_sel_b = 1'b0; cal_strobe = 1'b1;
        repeat (4) @(negedge clk);
        cal_strobe = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && not_ready == 1'b1, "R10 mid-step reset",
              int'({busy, not_ready}), 1);
        check(seq_error == 1'b0, "R10 error cleared", int'(seq_error), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: gain right after reset is refused
        run_step(1, 4, 1'b0, 1, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule